// File: doc/BRIEF.md
# Power-Cycling Serial ADC Controller

This block is the host-side master for a 12-bit serial converter that is kept powered down between samples. The converter sees one frame of 16 serial clocks per transfer, with its select line held low for the whole frame. In each frame the block sends a control word and receives a channel tag plus the conversion result. A converter that has powered itself down needs one full frame to wake. The block therefore remembers whether the converter is asleep. When it is, the block runs a wake-up frame, discards its result, and only then runs the frame whose data it keeps. A converter that was left in normal mode is sampled with a single frame.

A conversion is requested with a one-cycle `start` strobe, together with a channel number and a power-mode choice. The strobe is accepted only while `busy` is low. The result comes out on a valid/ready interface. Once `res_valid` is raised, it stays high with `res_chan` and `res_data` unchanged until a cycle in which `res_ready` is also high. The transfer happens on that cycle. Back-pressure from the consumer holds off the next request, because `busy` stays high until the result has been taken.

Top module: `adc_pc_top`

## Requirements
- R1: `spi_sclk` rests high while `spi_cs_n` is high. Each frame holds `spi_cs_n` low for exactly 16 falling edges of `spi_sclk`. Each half period of `spi_sclk` lasts CLK_DIV system clocks, so consecutive falling edges are 2*CLK_DIV clocks apart.
- R2: The control word goes out on `spi_mosi` MSB first. It is {1 (write), channel[2:0], PM1, PM0, ten zeros}. The first bit is driven when `spi_cs_n` falls, and each later bit is driven at a rising edge, so `spi_mosi` is stable at every falling edge.
- R3: In the frame whose data is kept, PM1 = PM0 = `mode_normal`. A 0 selects automatic power-down after the frame, and a 1 selects normal mode.
- R4: The converter counts as asleep after reset and after any frame sent with PM1 = 0. A request made while it is asleep first runs a wake-up frame with PM1 = PM0 = 1 and the same channel, and then runs the data frame.
- R5: The data returned in a wake-up frame never reaches the result output. Each accepted request produces exactly one result.
- R6: A request made while the converter is awake (the previous data frame used normal mode) runs exactly one frame.
- R7: `spi_miso` is sampled at each falling edge, MSB first. In the 16-bit returned word, bit 15 is ignored, bits 14:12 become `res_chan` and bits 11:0 become `res_data`.
- R8: Between frames, `spi_cs_n` stays high for at least 2*GAP_SCLKS*CLK_DIV system clocks.
- R9: `res_valid` stays high with stable `res_chan` and `res_data` until a cycle with `res_ready` high. It is low on the next cycle.
- R10: `busy` is high from the cycle after an accepted `start` until the result is taken, and it covers every cycle in which `res_valid` is high. A `start` while `busy` is high is ignored. Channel and mode are latched when the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion request strobe, accepted when busy is low |
| chan_sel | input | 3 | Channel to convert, latched on acceptance |
| mode_normal | input | 1 | 1: leave converter powered, 0: power down after each frame |
| spi_sclk | output | 1 | Serial clock to the converter |
| spi_cs_n | output | 1 | Active-low frame select |
| spi_mosi | output | 1 | Control word to the converter |
| spi_miso | input | 1 | Returned word from the converter |
| busy | output | 1 | Request in progress or result not yet taken |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer accepts result |
| res_chan | output | 3 | Channel tag from the returned word |
| res_data | output | 12 | Conversion result |

## Verification
A model of the converter on the bench tracks its own sleep state from the PM1 bit it receives. It answers a wake-up frame with a pattern that never matches a real sample. A skipped or extra dummy frame therefore shows up both as a wrong result and as a wrong frame count. Directed sequences walk the sleep-state transitions: power-down after power-down, normal from asleep, normal from awake, and power-down from awake. Each of these separates the dummy-frame decision from the mode bits that are sent. Random channels, modes, returned words (some with bit 15 set) and consumer stall lengths then show whether results stay held under back-pressure, whether strobes during a stall are ignored, and whether the channel is latched at acceptance and not at frame time.

// File: rtl/adc_pc_pkg.sv
package adc_pc_pkg;

  localparam int FRAME_BITS = 16;
  localparam int CHID_W     = 3;
  localparam int RES_W      = 12;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_LAUNCH_WAKE,
    SQ_RUN_WAKE,
    SQ_LAUNCH_DATA,
    SQ_RUN_DATA,
    SQ_FINISH
  } seq_state_t;

  typedef enum logic [1:0] {
    EN_IDLE,
    EN_SHIFT,
    EN_GAP
  } eng_state_t;

  // Outgoing control word: write flag, channel, two power-mode bits, zero fill.
  function automatic logic [FRAME_BITS-1:0] build_ctrl(
    input logic [CHID_W-1:0] ch,
    input logic              pm1,
    input logic              pm0
  );
    return {1'b1, ch, pm1, pm0, {(FRAME_BITS-CHID_W-3){1'b0}}};
  endfunction

endpackage

// File: rtl/adc_pc_tick.sv
module adc_pc_tick #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!en || cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = en && (cnt == LAST);
endmodule

// File: rtl/adc_pc_frame.sv
module adc_pc_frame
  import adc_pc_pkg::*;
#(
  parameter int CLK_DIV   = 2,
  parameter int GAP_SCLKS = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  go,
  input  logic [FRAME_BITS-1:0] tx_word,
  input  logic                  miso,
  output logic                  sclk,
  output logic                  cs_n,
  output logic                  mosi,
  output logic                  done,
  output logic [FRAME_BITS-1:0] rx_word,
  output logic                  idle
);
  localparam int BCW        = $clog2(FRAME_BITS);
  localparam int GAP_HALVES = 2 * GAP_SCLKS;
  localparam int GCW        = $clog2(GAP_HALVES + 1);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(FRAME_BITS - 1);
  localparam logic [GCW-1:0] LAST_GAP = GCW'(GAP_HALVES - 1);

  eng_state_t            st;
  logic                  tick;
  logic [BCW-1:0]        bit_idx;
  logic [GCW-1:0]        gap_cnt;
  logic [FRAME_BITS-1:0] tx_sh;
  logic [FRAME_BITS-1:0] rx_sh;

  adc_pc_tick #(.DIV(CLK_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (st != EN_IDLE),
    .tick (tick)
  );

  assign idle = (st == EN_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= EN_IDLE;
      sclk    <= 1'b1;
      cs_n    <= 1'b1;
      mosi    <= 1'b0;
      done    <= 1'b0;
      bit_idx <= '0;
      gap_cnt <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      rx_word <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        EN_IDLE: begin
          if (go) begin
            cs_n    <= 1'b0;
            sclk    <= 1'b1;
            mosi    <= tx_word[FRAME_BITS-1];
            tx_sh   <= {tx_word[FRAME_BITS-2:0], 1'b0};
            bit_idx <= '0;
            st      <= EN_SHIFT;
          end
        end
        EN_SHIFT: begin
          if (tick) begin
            if (sclk) begin
              sclk  <= 1'b0;
              rx_sh <= {rx_sh[FRAME_BITS-2:0], miso};
            end else begin
              sclk <= 1'b1;
              if (bit_idx == LAST_BIT) begin
                cs_n    <= 1'b1;
                mosi    <= 1'b0;
                done    <= 1'b1;
                rx_word <= rx_sh;
                gap_cnt <= '0;
                st      <= EN_GAP;
              end else begin
                bit_idx <= bit_idx + 1'b1;
                mosi    <= tx_sh[FRAME_BITS-1];
                tx_sh   <= {tx_sh[FRAME_BITS-2:0], 1'b0};
              end
            end
          end
        end
        EN_GAP: begin
          if (tick) begin
            if (gap_cnt == LAST_GAP) begin
              st <= EN_IDLE;
            end else begin
              gap_cnt <= gap_cnt + 1'b1;
            end
          end
        end
        default: st <= EN_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_pc_outreg.sv
module adc_pc_outreg #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= load_data;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_pc_top.sv
module adc_pc_top
  import adc_pc_pkg::*;
#(
  parameter int CLK_DIV   = 2,
  parameter int GAP_SCLKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CHID_W-1:0] chan_sel,
  input  logic              mode_normal,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              busy,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [CHID_W-1:0] res_chan,
  output logic [RES_W-1:0]  res_data
);
  localparam int OUT_W = CHID_W + RES_W;

  seq_state_t            sq;
  logic                  asleep;
  logic [CHID_W-1:0]     ch_q;
  logic                  mode_q;
  logic                  eng_idle;
  logic                  eng_done;
  logic                  frame_go;
  logic [FRAME_BITS-1:0] tx_word;
  logic [FRAME_BITS-1:0] rx_word;
  logic                  out_load;
  logic [OUT_W-1:0]      out_bus;

  assign busy     = (sq != SQ_IDLE);
  assign frame_go = eng_idle && (sq == SQ_LAUNCH_WAKE || sq == SQ_LAUNCH_DATA);
  assign tx_word  = (sq == SQ_LAUNCH_WAKE) ? build_ctrl(ch_q, 1'b1, 1'b1)
                                           : build_ctrl(ch_q, mode_q, mode_q);
  assign out_load = (sq == SQ_RUN_DATA) && eng_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq     <= SQ_IDLE;
      asleep <= 1'b1;
      ch_q   <= '0;
      mode_q <= 1'b0;
    end else begin
      unique case (sq)
        SQ_IDLE: begin
          if (start) begin
            ch_q   <= chan_sel;
            mode_q <= mode_normal;
            sq     <= asleep ? SQ_LAUNCH_WAKE : SQ_LAUNCH_DATA;
          end
        end
        SQ_LAUNCH_WAKE: if (frame_go) sq <= SQ_RUN_WAKE;
        SQ_RUN_WAKE: begin
          if (eng_done) begin
            asleep <= 1'b0;
            sq     <= SQ_LAUNCH_DATA;
          end
        end
        SQ_LAUNCH_DATA: if (frame_go) sq <= SQ_RUN_DATA;
        SQ_RUN_DATA: begin
          if (eng_done) begin
            asleep <= ~mode_q;
            sq     <= SQ_FINISH;
          end
        end
        SQ_FINISH: if (eng_idle && !res_valid) sq <= SQ_IDLE;
        default: sq <= SQ_IDLE;
      endcase
    end
  end

  adc_pc_frame #(.CLK_DIV(CLK_DIV), .GAP_SCLKS(GAP_SCLKS)) u_frame (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (frame_go),
    .tx_word(tx_word),
    .miso   (spi_miso),
    .sclk   (spi_sclk),
    .cs_n   (spi_cs_n),
    .mosi   (spi_mosi),
    .done   (eng_done),
    .rx_word(rx_word),
    .idle   (eng_idle)
  );

  adc_pc_outreg #(.W(OUT_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (out_load),
    .load_data(rx_word[OUT_W-1:0]),
    .out_valid(res_valid),
    .out_ready(res_ready),
    .out_data (out_bus)
  );

  assign res_chan = out_bus[OUT_W-1:RES_W];
  assign res_data = out_bus[RES_W-1:0];
endmodule

// File: rtl/adc_pc_checker.sv
module adc_pc_checker #(
  parameter int CLK_DIV   = 2,
  parameter int GAP_SCLKS = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        spi_cs_n,
  input logic        spi_sclk,
  input logic        spi_mosi,
  input logic        busy,
  input logic        res_valid,
  input logic        res_ready,
  input logic [2:0]  res_chan,
  input logic [11:0] res_data
);
  localparam int GAP_MIN = 2 * GAP_SCLKS * CLK_DIV;

  logic        cs_q, sclk_q;
  logic [4:0]  fall_cnt;
  logic [15:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q     <= 1'b1;
      sclk_q   <= 1'b1;
      fall_cnt <= '0;
      hi_cnt   <= 16'hFFFF;
    end else begin
      cs_q   <= spi_cs_n;
      sclk_q <= spi_sclk;
      if (cs_q && !spi_cs_n)
        fall_cnt <= '0;
      else if (!spi_cs_n && sclk_q && !spi_sclk)
        fall_cnt <= fall_cnt + 1'b1;
      if (!spi_cs_n)
        hi_cnt <= '0;
      else if (hi_cnt != 16'hFFFF)
        hi_cnt <= hi_cnt + 1'b1;
    end
  end

  assert_sclk_rest_R1: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> spi_sclk);

  assert_sixteen_falls_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> fall_cnt == 5'd16);

  assert_mosi_settled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n && $fell(spi_sclk)) |-> $stable(spi_mosi));

  assert_select_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> hi_cnt >= 16'(GAP_MIN));

  assert_hold_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_chan) && $stable(res_data)));

  assert_pop_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> !res_valid);

  assert_busy_cover_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> busy);
endmodule

bind adc_pc_top adc_pc_checker #(.CLK_DIV(CLK_DIV), .GAP_SCLKS(GAP_SCLKS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .spi_cs_n (spi_cs_n),
  .spi_sclk (spi_sclk),
  .spi_mosi (spi_mosi),
  .busy     (busy),
  .res_valid(res_valid),
  .res_ready(res_ready),
  .res_chan (res_chan),
  .res_data (res_data)
);

// File: tb/test_adc_pc_top.sv
`timescale 1ns/1ps
module test_adc_pc_top;
  localparam int DIV = 2;
  localparam int GAP = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] chan_sel = '0;
  logic mode_normal = 1'b0;
  logic spi_sclk, spi_cs_n, spi_mosi;
  logic spi_miso = 1'b0;
  logic busy, res_valid;
  logic res_ready = 1'b0;
  logic [2:0] res_chan;
  logic [11:0] res_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adc_pc_top #(.CLK_DIV(DIV), .GAP_SCLKS(GAP)) i_adc_pc_top (
    .clk(clk), .rst_n(rst_n), .start(start), .chan_sel(chan_sel),
    .mode_normal(mode_normal), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .busy(busy),
    .res_valid(res_valid), .res_ready(res_ready), .res_chan(res_chan),
    .res_data(res_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_ctrl(input logic [2:0] ch, input logic pm1, input logic pm0);
    return {1'b1, ch, pm1, pm0, 10'd0};
  endfunction

  // ---------------- converter model ----------------
  logic [2:0]  req_chan = '0;
  logic        req_mode = 1'b0;
  logic        m_asleep = 1'b1;
  logic        m_dummy  = 1'b0;
  logic        frame_on = 1'b0;
  logic [15:0] m_word = '0;
  logic [12:0] m_ctrl = '0;
  int          m_falls = 0;
  int          last_fall = 0;
  int          rise_cyc = -1000;
  int          frames = 0;
  int          wakes = 0;
  logic [11:0] exp_data = '0;

  always @(negedge spi_cs_n) if (rst_n) begin
    chk((cyc - rise_cyc) >= 2*GAP*DIV, "R8 select gap", cyc - rise_cyc, 2*GAP*DIV);
    frame_on = 1'b1;
    m_dummy  = m_asleep;
    m_asleep = 1'b0;
    m_falls  = 0;
    m_ctrl   = '0;
    if (m_dummy) m_word = {1'b1, 15'($urandom) | 15'h7000};
    else         m_word = {1'($urandom), req_chan, 12'($urandom)};
    spi_miso = m_word[15];
  end

  always @(negedge spi_sclk) if (rst_n && frame_on) begin
    m_falls++;
    if (m_falls > 1)
      chk(cyc - last_fall == 2*DIV, "R1 sclk period", cyc - last_fall, 2*DIV);
    last_fall = cyc;
    if (m_falls <= 13) m_ctrl = {m_ctrl[11:0], spi_mosi};
    if (m_falls == 14 && m_ctrl[8] == 1'b0) m_asleep = 1'b1;
  end

  always @(posedge spi_sclk) if (rst_n && frame_on && m_falls < 16)
    spi_miso = m_word[15 - m_falls];

  always @(posedge spi_cs_n) if (rst_n && frame_on) begin
    logic [15:0] e;
    frame_on = 1'b0;
    rise_cyc = cyc;
    frames++;
    chk(m_falls == 16, "R1 falls per frame", m_falls, 16);
    if (m_dummy) begin
      wakes++;
      e = exp_ctrl(req_chan, 1'b1, 1'b1);
      chk(m_ctrl == e[15:3], "R4 wake ctrl word", m_ctrl, e[15:3]);
    end else begin
      e = exp_ctrl(req_chan, req_mode, req_mode);
      chk(m_ctrl == e[15:3], "R2 R3 data ctrl word", m_ctrl, e[15:3]);
      exp_data = m_word[11:0];
    end
  end

  // ---------------- stimulus ----------------
  logic exp_asleep = 1'b1;

  task automatic do_conv(input logic [2:0] ch, input logic mode, input int stall);
    int f0, w0, fe;
    while (busy) @(negedge clk);
    f0 = frames; w0 = wakes;
    req_chan = ch; req_mode = mode;
    start = 1'b1; chan_sel = ch; mode_normal = mode;
    @(negedge clk);
    start = 1'b0; chan_sel = 3'($urandom); mode_normal = 1'($urandom);
    chk(busy == 1'b1, "R10 busy after accept", busy, 1);
    while (!res_valid) @(negedge clk);
    chk(res_chan == ch, "R7 channel tag", res_chan, ch);
    chk(res_data == exp_data, "R5 R7 result data", res_data, exp_data);
    fe = exp_asleep ? 2 : 1;
    chk(frames - f0 == fe, exp_asleep ? "R4 wake then data frames" : "R6 single frame",
        frames - f0, fe);
    chk(wakes - w0 == (exp_asleep ? 1 : 0), "R5 R4 wake frame count", wakes - w0, exp_asleep);
    for (int i = 0; i < stall; i++) begin
      start = (i == 0);
      @(negedge clk);
      chk(res_valid && res_data == exp_data && res_chan == ch, "R9 held under stall",
          {res_valid, res_chan, res_data}, {1'b1, ch, exp_data});
    end
    start = 1'b0;
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk(res_valid == 1'b0, "R9 popped after ready", res_valid, 0);
    repeat (3) @(negedge clk);
    chk(frames - f0 == fe, "R10 start during busy ignored", frames - f0, fe);
    chk(res_valid == 1'b0, "R5 one result per request", res_valid, 0);
    exp_asleep = ~mode;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    chk(spi_cs_n && spi_sclk, "R1 reset idle lines", {spi_cs_n, spi_sclk}, 2'b11);
    chk(!res_valid && !busy, "R10 reset idle", {res_valid, busy}, 2'b00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    do_conv(3'd5, 1'b0, 0);  // asleep after reset
    do_conv(3'd2, 1'b0, 3);  // asleep again after power-down
    do_conv(3'd7, 1'b1, 0);  // normal requested while asleep
    do_conv(3'd1, 1'b1, 5);  // awake: single frame
    do_conv(3'd0, 1'b0, 1);  // awake, then power down
    do_conv(3'd6, 1'b0, 2);  // asleep again
    for (int n = 0; n < 30; n++)
      do_conv(3'($urandom), 1'($urandom), int'($urandom % 7));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule